// File: doc/BRIEF.md
# Delay Mode Outlier Filter

The block cleans a stream of timestamp pairs before a line fit. Each pair carries a send time, counted by the local controller's timer, and the matching arrival time on an absolute time base. Both are counts of microseconds. The block takes the difference, send minus arrival, as the pair's delay. It sorts each delay into a one-millisecond bin and counts the pairs that fall in each bin.

The block collects a window of pairs and stores them. It then searches the bin counts for the most populated bin. In a second pass over the stored pairs, a pair is kept when its raw delay lies close enough to the centre of that bin, and kept pairs leave on a valid/ready stream in arrival order. Late retransmitted packets are removed this way. A delay population split into two nearby bands does not shift the reference point, because the reference is the mode and not an average. Once a window has drained, the bin counts are cleared and the next window begins.

Top module: `delay_mode_filter`

## Requirements
- R1: The delay of a pair is in_tx minus in_rx, taken as a signed two's-complement value in microseconds. Every emitted pair presents this value on out_delay, together with its original in_tx and in_rx values.
- R2: A delay d falls in bin floor(d / US_PER_BIN), rounding toward minus infinity. For example, -1 µs falls in bin -1 and 999 µs falls in bin 0.
- R3: After a window, out_mode holds the signed index of the bin with the highest count. It remains valid until the next window's search begins.
- R4: When two or more bins share the highest count, the bin with the lowest signed index is the mode.
- R5: A pair with delay d is kept only if |d - (mode*US_PER_BIN + US_PER_BIN/2)| <= TOL_US. A distance of exactly TOL_US is kept, and one microsecond more is rejected.
- R6: The bins cover -NBINS/2 to NBINS/2-1. A delay whose bin lies outside that range is counted in the nearest end bin and is always rejected.
- R7: Kept pairs are emitted in arrival order. While out_valid is high and out_ready is low, out_valid and the output data stay unchanged.
- R8: in_ready is low while counts are cleared, during the search and during the emit pass. It is high again exactly NBINS cycles after reset is released. After each accepted pair it is low for one cycle.
- R9: A window holds WIN pairs. The next window starts with every bin count at zero, so its mode depends only on its own pairs.
- R10: During and right after a synchronous active-high reset, in_ready and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block accepts a pair this cycle |
| in_tx | input | TS_W | Send timestamp, µs |
| in_rx | input | TS_W | Arrival timestamp, µs |
| out_valid | output | 1 | Kept pair valid |
| out_ready | input | 1 | Downstream accepts the kept pair |
| out_tx | output | TS_W | Send timestamp of kept pair |
| out_rx | output | TS_W | Arrival timestamp of kept pair |
| out_delay | output | TS_W | Signed delay of kept pair, µs |
| out_mode | output | clog2(NBINS) | Signed mode bin of the last window |

## Verification
in_ready is combinational from the state register, so the bench reads it at the falling edge. The clear lasts NBINS rising edges after reset is released, and the bench expects ready at exactly that falling edge. One falling edge after each accept, the bench expects ready to be low. Output registers change only at a rising edge. The bench therefore decides a handshake at a falling edge, from out_valid and the out_ready it has just driven, and records the data there. It waits for ready to return and then checks out_mode, so the number of emit cycles never enters an expected value. Five windows are driven: a mixed window, tolerance edges, a tie, two bands with retransmission outliers, and a negative overflow mode. Backpressure is applied in four of them.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR, ST_FILL, ST_INC, ST_SCAN, ST_READ, ST_EVAL, ST_SEND
  } dmf_state_e;
endpackage

// File: rtl/dmf_ram.sv
// Simple dual-port memory with a registered read, shaped for block RAM.
module dmf_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dmf_quant.sv
// Floor-quantizes a signed microsecond delay to a bin index with end clamping.
module dmf_quant #(
  parameter int TS_W       = 32,
  parameter int NBINS      = 256,
  parameter int US_PER_BIN = 1000
) (
  input  logic signed [TS_W-1:0]          delay_i,
  output logic        [$clog2(NBINS)-1:0] idx_o,
  output logic                            sat_o
);
  localparam int BIN_W = $clog2(NBINS);
  localparam logic signed [TS_W-1:0] UPB = TS_W'(US_PER_BIN);
  localparam logic signed [TS_W-1:0] LO  = -$signed(TS_W'(NBINS / 2));
  localparam logic signed [TS_W-1:0] HI  = $signed(TS_W'(NBINS / 2 - 1));

  logic signed [TS_W-1:0] quo, fl;

  always_comb begin
    quo = delay_i / UPB;
    fl  = ((delay_i < 0) && (quo * UPB != delay_i)) ? quo - 1 : quo;
    if (fl < LO) begin
      idx_o = '0;
      sat_o = 1'b1;
    end else if (fl > HI) begin
      idx_o = BIN_W'(NBINS - 1);
      sat_o = 1'b1;
    end else begin
      idx_o = BIN_W'(fl - LO);
      sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/delay_mode_filter.sv
module delay_mode_filter import dmf_pkg::*; #(
  parameter int TS_W       = 32,
  parameter int WIN        = 64,
  parameter int NBINS      = 256,
  parameter int US_PER_BIN = 1000,
  parameter int TOL_US     = 2500
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [TS_W-1:0]                 in_tx,
  input  logic [TS_W-1:0]                 in_rx,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [TS_W-1:0]                 out_tx,
  output logic [TS_W-1:0]                 out_rx,
  output logic signed [TS_W-1:0]          out_delay,
  output logic signed [$clog2(NBINS)-1:0] out_mode
);
  localparam int BIN_W = $clog2(NBINS);
  localparam int WA_W  = $clog2(WIN);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int BUF_W = 2 * TS_W + 1;
  localparam logic signed [TS_W-1:0] UPB  = TS_W'(US_PER_BIN);
  localparam logic signed [TS_W-1:0] HBIN = TS_W'(US_PER_BIN / 2);
  localparam logic signed [TS_W-1:0] TOL  = TS_W'(TOL_US);

  dmf_state_e state;
  logic [BIN_W-1:0] clr_cnt, inc_idx, best_idx, q_idx, hist_wa, hist_ra;
  logic [BIN_W:0]   scan_cnt;
  logic [WA_W-1:0]  wr_ptr, rd_ptr;
  logic             last_q, q_sat, accept, hist_we, b_sat, keep;
  logic [CNT_W-1:0] best_cnt, hist_rd, hist_wd;
  logic [BUF_W-1:0] buf_rd;
  logic [TS_W-1:0]  b_tx, b_rx;
  logic signed [TS_W-1:0] in_delay, b_delay, mode_s, centre, dev;

  assign in_ready = (state == ST_FILL);
  assign accept   = in_valid && in_ready;
  assign in_delay = $signed(in_tx - in_rx);

  dmf_quant #(.TS_W(TS_W), .NBINS(NBINS), .US_PER_BIN(US_PER_BIN)) u_quant (
    .delay_i(in_delay), .idx_o(q_idx), .sat_o(q_sat)
  );

  // Bin counters: cleared sequentially, incremented read-modify-write, then scanned.
  always_comb begin
    hist_we = (state == ST_CLEAR) || (state == ST_INC);
    hist_wa = (state == ST_CLEAR) ? clr_cnt : inc_idx;
    hist_wd = (state == ST_CLEAR) ? '0 : hist_rd + CNT_W'(1);
    hist_ra = (state == ST_SCAN) ? scan_cnt[BIN_W-1:0] : q_idx;
  end

  dmf_ram #(.DW(CNT_W), .DEPTH(NBINS)) u_hist (
    .clk(clk), .we(hist_we), .waddr(hist_wa), .wdata(hist_wd),
    .raddr(hist_ra), .rdata(hist_rd)
  );

  dmf_ram #(.DW(BUF_W), .DEPTH(WIN)) u_buf (
    .clk(clk), .we(accept), .waddr(wr_ptr), .wdata({q_sat, in_tx, in_rx}),
    .raddr(rd_ptr), .rdata(buf_rd)
  );

  // Rejection test against the centre of the mode bin, on the raw delay.
  assign {b_sat, b_tx, b_rx} = buf_rd;
  assign out_mode = best_idx - BIN_W'(NBINS / 2);
  assign mode_s   = TS_W'(out_mode);
  assign centre   = mode_s * UPB + HBIN;
  assign b_delay  = $signed(b_tx - b_rx);
  assign dev      = b_delay - centre;
  assign keep     = !b_sat && (dev <= TOL) && (dev >= -TOL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CLEAR;
      clr_cnt   <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      last_q    <= 1'b0;
      inc_idx   <= '0;
      scan_cnt  <= '0;
      best_cnt  <= '0;
      best_idx  <= '0;
      out_valid <= 1'b0;
      out_tx    <= '0;
      out_rx    <= '0;
      out_delay <= '0;
    end else begin
      case (state)
        ST_CLEAR: begin
          clr_cnt <= clr_cnt + BIN_W'(1);
          if (clr_cnt == BIN_W'(NBINS - 1)) begin
            clr_cnt <= '0;
            state   <= ST_FILL;
          end
        end
        ST_FILL: if (accept) begin
          inc_idx <= q_idx;
          state   <= ST_INC;
          if (wr_ptr == WA_W'(WIN - 1)) begin
            wr_ptr <= '0;
            last_q <= 1'b1;
          end else begin
            wr_ptr <= wr_ptr + WA_W'(1);
            last_q <= 1'b0;
          end
        end
        ST_INC: begin
          if (last_q) begin
            state    <= ST_SCAN;
            scan_cnt <= '0;
            best_cnt <= '0;
            best_idx <= '0;
          end else begin
            state <= ST_FILL;
          end
        end
        ST_SCAN: begin
          scan_cnt <= scan_cnt + (BIN_W+1)'(1);
          if ((scan_cnt != '0) && (hist_rd > best_cnt)) begin
            best_cnt <= hist_rd;
            best_idx <= BIN_W'(scan_cnt - (BIN_W+1)'(1));
          end
          if (scan_cnt == (BIN_W+1)'(NBINS)) begin
            state  <= ST_READ;
            rd_ptr <= '0;
          end
        end
        ST_READ: state <= ST_EVAL;
        ST_EVAL: begin
          if (keep) begin
            out_tx    <= b_tx;
            out_rx    <= b_rx;
            out_delay <= b_delay;
            out_valid <= 1'b1;
            state     <= ST_SEND;
          end else if (rd_ptr == WA_W'(WIN - 1)) begin
            state <= ST_CLEAR;
          end else begin
            rd_ptr <= rd_ptr + WA_W'(1);
            state  <= ST_READ;
          end
        end
        ST_SEND: if (out_ready) begin
          out_valid <= 1'b0;
          if (rd_ptr == WA_W'(WIN - 1)) begin
            state <= ST_CLEAR;
          end else begin
            rd_ptr <= rd_ptr + WA_W'(1);
            state  <= ST_READ;
          end
        end
        default: state <= ST_CLEAR;
      endcase
    end
  end

  logic signed [TS_W-1:0] out_dev;
  assign out_dev = out_delay - (TS_W'(out_mode) * UPB + HBIN);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_tx) && $stable(out_rx)); // R7
  AST_KEEP_TOL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dev <= TOL) && (out_dev >= -TOL)); // R5
  AST_NO_INPUT_WHILE_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R8
  AST_ONE_PER_TWO: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INC) |-> (hist_rd < CNT_W'(WIN))); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !in_ready); // R10
endmodule

// File: tb/test_delay_mode_filter.sv
module test_delay_mode_filter;
  localparam int WIN = 8;
  localparam int NB  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_tx = '0, in_rx = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [31:0] out_tx, out_rx;
  logic signed [31:0] out_delay;
  logic signed [3:0] out_mode;

  delay_mode_filter #(.TS_W(32), .WIN(WIN), .NBINS(NB), .US_PER_BIN(1000), .TOL_US(2500)) i_delay_mode_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tx(in_tx), .in_rx(in_rx), .out_valid(out_valid), .out_ready(out_ready),
    .out_tx(out_tx), .out_rx(out_rx), .out_delay(out_delay), .out_mode(out_mode)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int dly[WIN];
  int txa[WIN], rxa[WIN];
  int ktx[WIN], krx[WIN], kd[WIN];
  int nexp, emode;

  task automatic chk(input bit ok, input string req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  function automatic int floor_bin(input int d);
    int q = d / 1000;
    if (d < 0 && q * 1000 != d) q = q - 1;
    return q;
  endfunction

  task automatic load(input int a0, input int a1, input int a2, input int a3,
                      input int a4, input int a5, input int a6, input int a7);
    dly[0] = a0; dly[1] = a1; dly[2] = a2; dly[3] = a3;
    dly[4] = a4; dly[5] = a5; dly[6] = a6; dly[7] = a7;
  endtask

  // Reference model built from the requirements.
  task automatic model();
    int hist[NB];
    int best;
    for (int b = 0; b < NB; b++) hist[b] = 0;
    for (int i = 0; i < WIN; i++) begin
      int q = floor_bin(dly[i]);
      if (q < -NB/2) q = -NB/2;
      if (q > NB/2 - 1) q = NB/2 - 1;
      hist[q + NB/2]++;
    end
    best = 0;
    emode = -NB/2;
    for (int b = 0; b < NB; b++)
      if (hist[b] > best) begin
        best = hist[b];
        emode = b - NB/2;
      end
    nexp = 0;
    for (int i = 0; i < WIN; i++) begin
      int q = floor_bin(dly[i]);
      int dv = dly[i] - (emode * 1000 + 500);
      bit sat = (q < -NB/2) || (q > NB/2 - 1);
      if (!sat && dv <= 2500 && dv >= -2500) begin
        ktx[nexp] = txa[i];
        krx[nexp] = rxa[i];
        kd[nexp]  = dly[i];
        nexp++;
      end
    end
  endtask

  task automatic send_pair(input int tx, input int rx);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_tx = tx;
    in_rx = rx;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R8", "ready one cycle after accept", int'(in_ready), 0);
  endtask

  task automatic run_window(input int w, input bit bp, input string ctag, input string mtag);
    int k = 0;
    int cyc = 0;
    for (int i = 0; i < WIN; i++) begin
      rxa[i] = 1000000 + w * 100000 + i * 7000;
      txa[i] = rxa[i] + dly[i];
    end
    model();
    for (int i = 0; i < WIN; i++) send_pair(txa[i], rxa[i]);
    forever begin
      @(negedge clk);
      out_ready = bp ? (cyc % 3 != 2) : 1'b1;
      cyc++;
      if (out_valid && out_ready) begin
        if (k < nexp) begin
          chk(out_tx == 32'(ktx[k]), "R7", "tx in order", int'(out_tx), ktx[k]);
          chk(out_rx == 32'(krx[k]), "R7", "rx in order", int'(out_rx), krx[k]);
          chk(out_delay == kd[k], "R1", "delay", int'(out_delay), kd[k]);
        end else begin
          chk(1'b0, ctag, "unexpected extra kept pair", int'(out_delay), 0);
        end
        k++;
      end
      if (in_ready) break;
      if (cyc > 5000) begin
        chk(1'b0, ctag, "window did not drain", cyc, 0);
        break;
      end
    end
    out_ready = 1'b0;
    chk(k == nexp, ctag, "kept pair count", k, nexp);
    chk(int'(out_mode) == emode, mtag, "mode bin", int'(out_mode), emode);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R10", "ready in reset", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R10", "valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    // R8: clear takes NBINS rising edges after release
    for (int c = 0; c < NB - 1; c++) begin
      @(negedge clk);
      if (in_ready) chk(1'b0, "R8", "ready early during clear", c, NB);
    end
    @(negedge clk);
    chk(in_ready == 1'b1, "R8", "ready after clear", int'(in_ready), 1);

    // R6: mixed window, one positive overflow, one far outlier
    load(2100, 2300, 2900, 2050, 9000, 2600, 5600, -700);
    run_window(0, 1'b0, "R6", "R3");
    // R5: tolerance edges around mode bin 0 (centre 500), fresh counts (R9)
    load(100, 200, 300, 3000, 3001, -2000, -2001, 400);
    run_window(1, 1'b1, "R5", "R9");
    // R4: tie between bins -3 and 4
    load(-2500, -2200, -2900, 4100, 4200, 4900, 0, 1000);
    run_window(2, 1'b1, "R4", "R4");
    // R2: two bands near a bin edge plus retransmission outliers
    load(-4800, -4300, -3200, -4500, 3500, -3900, -4100, 6000);
    run_window(3, 1'b1, "R2", "R3");
    // R6: negative overflow pairs form the mode but are never kept
    load(-20000, -8000, -30000, -7900, -9000, -5100, -8001, -4900);
    run_window(4, 1'b1, "R6", "R3");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule